// File: doc/BRIEF.md
# Multi-mode operand address unit

This unit takes one operand specifier for an accumulator-style instruction. The specifier has a four-bit mode code, an 8-bit address field A, a 4-bit register index R and the current program counter. From these the unit works out where the operand lives and fetches it. It reads one word from an external register file and issues zero, one or two reads to a single-port memory that returns data one cycle after the request. When the unit finishes, it presents the operand and the effective address and pulses `done` for one cycle.

The unit supports nine modes: immediate, direct, indirect, register, register-indirect, displacement, PC-relative, pre-indexed and post-indexed. The two indexed modes differ in when the register is added. Pre-indexing adds R before the pointer read. Post-indexing adds R to the pointer after it has been read. A controlling sequencer raises `start` while `busy` is low, then waits for `done`.

The controller moves through these states:
- IDLE goes to EVAL on an accepted start.
- EVAL reads the register and forms the first address. It goes to FINISH when the mode needs no read, or to ISSUE1 otherwise.
- ISSUE1 drives the request and goes to WAIT1.
- WAIT1 captures the returned word. It goes to FINISH for single-read modes, or to ISSUE2 after forming the second address.
- ISSUE2 goes to WAIT2.
- WAIT2 captures the operand and goes to FINISH.
- FINISH pulses done and returns to IDLE.

Top module: `operand_resolver`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low, and `operand` and `eff_addr` are zero.
- R2: A `start` seen while `busy` is low captures mode, A, R and PC. A `start` while `busy` is high is ignored and has no effect on the result or on the memory reads.
- R3: `done` is high for exactly one cycle per operation. `operand` and `eff_addr` stay unchanged after `done` until a new operation is accepted.
- R4: Mode code 0 (immediate) yields operand = A and eff_addr = 0 with no memory read. Codes 9 to 15 behave the same way.
- R5: Mode code 3 (register) yields operand = reg[R] and eff_addr = 0 with no memory read.
- R6: Codes 1 (direct), 4 (register-indirect), 5 (displacement) and 6 (relative) make one read. The read address is A, reg[R], A+reg[R] and A+PC respectively. That address is eff_addr, and the word returned is the operand.
- R7: Code 2 (indirect) reads at A. The word returned is eff_addr, and a second read there returns the operand.
- R8: Code 7 (pre-indexed) reads at A+reg[R]. The word returned is eff_addr, and a second read there returns the operand.
- R9: Code 8 (post-indexed) reads at A. eff_addr is the word returned plus reg[R], and a second read there returns the operand.
- R10: All address sums wrap modulo 256.
- R11: Each memory request lasts one cycle, and the data is taken the cycle after. With n reads, `done` is high in the cycle after the (1+2n)-th clock edge following the edge that accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (honoured only when idle) |
| mode | input | 4 | Addressing mode code |
| addr_field | input | 8 | Address or constant field A |
| reg_idx | input | 4 | Register index R |
| pc | input | 8 | Current program counter |
| busy | output | 1 | Operation in progress |
| rf_idx | output | 4 | Register file read index |
| rf_data | input | 8 | Register file read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 8 | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid the cycle after the request |
| done | output | 1 | One-cycle completion pulse |
| operand | output | 8 | Fetched operand |
| eff_addr | output | 8 | Effective address (0 for immediate and register) |

## Verification
The hardest cases to reach are a second-read address that wraps past 255 and a `start` that arrives while the unit is mid-sequence. Post-indexed wrap depends on memory contents as well as the register. The bench therefore fills memory from an arithmetic pattern and loads registers with values near 255, so some pointer-plus-register sums must overflow. It also raises `start` with different mode and address inputs in the cycle after an operation is accepted. It then compares the read addresses, the read count and the result with its own model.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

    typedef enum logic [3:0] {
        AM_IMM  = 4'd0,
        AM_DIR  = 4'd1,
        AM_IND  = 4'd2,
        AM_REG  = 4'd3,
        AM_RIND = 4'd4,
        AM_DISP = 4'd5,
        AM_REL  = 4'd6,
        AM_PRE  = 4'd7,
        AM_POST = 4'd8
    } amode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EVAL,
        S_ISSUE1,
        S_WAIT1,
        S_ISSUE2,
        S_WAIT2,
        S_FINISH
    } rstate_e;

    // number of memory reads an addressing mode needs
    function automatic logic [1:0] reads_for(input logic [3:0] m);
        case (m)
            AM_DIR, AM_RIND, AM_DISP, AM_REL: reads_for = 2'd1;
            AM_IND, AM_PRE, AM_POST:          reads_for = 2'd2;
            default:                          reads_for = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/operand_resolver_addr.sv
module operand_resolver_addr
    import opaddr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]   mode_q,
    input  logic [W-1:0] a_q,
    input  logic [W-1:0] pc_q,
    input  logic [W-1:0] rv_now,
    input  logic [W-1:0] rv_q,
    input  logic [W-1:0] rdata,
    output logic [W-1:0] addr1,
    output logic [W-1:0] addr2
);

    // first read address, sums wrap at W bits
    always_comb begin
        unique case (mode_q)
            AM_RIND:         addr1 = rv_now;
            AM_DISP, AM_PRE: addr1 = a_q + rv_now;
            AM_REL:          addr1 = a_q + pc_q;
            default:         addr1 = a_q;
        endcase
    end

    // second read address: pointer word, indexed after the read for post mode
    always_comb begin
        if (mode_q == AM_POST) addr2 = rdata + rv_q;
        else                   addr2 = rdata;
    end

endmodule

// File: rtl/operand_resolver_ctrl.sv
module operand_resolver_ctrl
    import opaddr_pkg::*;
#(
    parameter int W      = 8,
    parameter int RIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic [W-1:0]      addr_field,
    input  logic [RIDX_W-1:0] reg_idx,
    input  logic [W-1:0]      pc,
    input  logic [W-1:0]      rf_data,
    input  logic [W-1:0]      mem_rdata,
    input  logic [W-1:0]      addr1,
    input  logic [W-1:0]      addr2,
    output logic [3:0]        mode_q,
    output logic [W-1:0]      a_q,
    output logic [W-1:0]      pc_q,
    output logic [W-1:0]      rv_q,
    output logic [RIDX_W-1:0] r_q,
    output logic              busy,
    output logic              mem_req,
    output logic [W-1:0]      mem_addr,
    output logic              done,
    output logic [W-1:0]      operand,
    output logic [W-1:0]      eff_addr
);

    rstate_e     state_q, state_d;
    logic [W-1:0] addr_q, operand_q, ea_q;
    logic [1:0]  nreads;
    logic        accept;

    assign nreads = reads_for(mode_q);
    assign accept = (state_q == S_IDLE) && start;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_EVAL;
            S_EVAL:   state_d = (nreads == 2'd0) ? S_FINISH : S_ISSUE1;
            S_ISSUE1: state_d = S_WAIT1;
            S_WAIT1:  state_d = (nreads == 2'd1) ? S_FINISH : S_ISSUE2;
            S_ISSUE2: state_d = S_WAIT2;
            S_WAIT2:  state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '0;
            a_q       <= '0;
            pc_q      <= '0;
            r_q       <= '0;
            rv_q      <= '0;
            addr_q    <= '0;
            operand_q <= '0;
            ea_q      <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        mode_q <= mode;
                        a_q    <= addr_field;
                        pc_q   <= pc;
                        r_q    <= reg_idx;
                    end
                end
                S_EVAL: begin
                    rv_q <= rf_data;
                    if (nreads == 2'd0) begin
                        operand_q <= (mode_q == AM_REG) ? rf_data : a_q;
                        ea_q      <= '0;
                    end else begin
                        addr_q <= addr1;
                    end
                end
                S_WAIT1: begin
                    if (nreads == 2'd1) begin
                        operand_q <= mem_rdata;
                        ea_q      <= addr_q;
                    end else begin
                        addr_q <= addr2;
                    end
                end
                S_WAIT2: begin
                    operand_q <= mem_rdata;
                    ea_q      <= addr_q;
                end
                default: ;
            endcase
        end
    end

    // outputs
    assign busy     = (state_q != S_IDLE);
    assign mem_req  = (state_q == S_ISSUE1) || (state_q == S_ISSUE2);
    assign mem_addr = addr_q;
    assign done     = (state_q == S_FINISH);
    assign operand  = operand_q;
    assign eff_addr = ea_q;

    // request counter used only by the checks below
    logic [1:0] req_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       req_cnt_q <= '0;
        else if (accept)  req_cnt_q <= '0;
        else if (mem_req) req_cnt_q <= req_cnt_q + 2'd1;
    end

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !$rose(!busy)) |=> ($stable(operand) && $stable(eff_addr)));

    a_r11_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r2_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(mode_q) && $stable(a_q) && $stable(r_q)));

    a_r11_read_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_cnt_q == reads_for(mode_q)));

    a_r5_reg_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (mode_q == AM_REG)) |-> !mem_req);

endmodule

// File: rtl/operand_resolver.sv
module operand_resolver #(
    parameter int W      = 8,
    parameter int RIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic [W-1:0]      addr_field,
    input  logic [RIDX_W-1:0] reg_idx,
    input  logic [W-1:0]      pc,
    output logic              busy,
    output logic [RIDX_W-1:0] rf_idx,
    input  logic [W-1:0]      rf_data,
    output logic              mem_req,
    output logic [W-1:0]      mem_addr,
    input  logic [W-1:0]      mem_rdata,
    output logic              done,
    output logic [W-1:0]      operand,
    output logic [W-1:0]      eff_addr
);

    logic [3:0]        mode_q;
    logic [W-1:0]      a_q, pc_q, rv_q, addr1, addr2;
    logic [RIDX_W-1:0] r_q;

    operand_resolver_ctrl #(.W(W), .RIDX_W(RIDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode       (mode),
        .addr_field (addr_field),
        .reg_idx    (reg_idx),
        .pc         (pc),
        .rf_data    (rf_data),
        .mem_rdata  (mem_rdata),
        .addr1      (addr1),
        .addr2      (addr2),
        .mode_q     (mode_q),
        .a_q        (a_q),
        .pc_q       (pc_q),
        .rv_q       (rv_q),
        .r_q        (r_q),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .done       (done),
        .operand    (operand),
        .eff_addr   (eff_addr)
    );

    operand_resolver_addr #(.W(W)) u_addr (
        .mode_q (mode_q),
        .a_q    (a_q),
        .pc_q   (pc_q),
        .rv_now (rf_data),
        .rv_q   (rv_q),
        .rdata  (mem_rdata),
        .addr1  (addr1),
        .addr2  (addr2)
    );

    assign rf_idx = r_q;

endmodule

// File: tb/operand_resolver_bench.sv
`timescale 1ns/1ps
module operand_resolver_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] mode = '0;
    logic [7:0] addr_field = '0;
    logic [3:0] reg_idx = '0;
    logic [7:0] pc = '0;
    logic       busy, mem_req, done;
    logic [3:0] rf_idx;
    logic [7:0] rf_data, mem_addr, operand, eff_addr;
    logic [7:0] mem_rdata = '0;

    logic [7:0] mem [256];
    logic [7:0] rf  [16];
    logic [7:0] rd_log [1024];
    int nrd = 0;
    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    operand_resolver u_operand_resolver (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .addr_field(addr_field), .reg_idx(reg_idx), .pc(pc), .busy(busy),
        .rf_idx(rf_idx), .rf_data(rf_data), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done),
        .operand(operand), .eff_addr(eff_addr)
    );

    assign rf_data = rf[rf_idx];

    // memory model: one cycle read latency, logs each request address
    always @(posedge clk) begin
        if (mem_req) begin
            mem_rdata <= mem[mem_addr];
            rd_log[nrd % 1024] <= mem_addr;
            nrd <= nrd + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            4'd3:                    return "R5";
            4'd1, 4'd4, 4'd5, 4'd6:  return "R6";
            4'd2:                    return "R7";
            4'd7:                    return "R8";
            4'd8:                    return "R9";
            default:                 return "R4";
        endcase
    endfunction

    // reference model from the requirements
    task automatic ref_op(input logic [3:0] m, input logic [7:0] a,
                          input logic [3:0] r, input logic [7:0] p,
                          output logic [7:0] op, output logic [7:0] ea,
                          output int n, output logic [7:0] a1, output logic [7:0] a2);
        logic [7:0] rv = rf[r];
        a1 = 0; a2 = 0;
        case (m)
            4'd3: begin n = 0; op = rv; ea = 0; end
            4'd1: begin n = 1; a1 = a; end
            4'd4: begin n = 1; a1 = rv; end
            4'd5: begin n = 1; a1 = a + rv; end
            4'd6: begin n = 1; a1 = a + p; end
            4'd2: begin n = 2; a1 = a; a2 = mem[a1]; end
            4'd7: begin n = 2; a1 = a + rv; a2 = mem[a1]; end
            4'd8: begin n = 2; a1 = a; a2 = mem[a1] + rv; end
            default: begin n = 0; op = a; ea = 0; end
        endcase
        if (n == 1) begin ea = a1; op = mem[a1]; end
        if (n == 2) begin ea = a2; op = mem[a2]; end
    endtask

    task automatic run_op(input logic [3:0] m, input logic [7:0] a,
                          input logic [3:0] r, input logic [7:0] p, input bit poke);
        logic [7:0] e_op, e_ea, a1, a2, held_op, held_ea;
        int n, n0, edges;
        string t;
        ref_op(m, a, r, p, e_op, e_ea, n, a1, a2);
        t = tag_of(m);
        @(negedge clk);
        mode = m; addr_field = a; reg_idx = r; pc = p; start = 1'b1;
        n0 = nrd;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        edges = 0;
        while (!done && edges < 20) begin
            if (poke && edges == 0) begin
                // R2: start while busy with other inputs must be ignored
                start = 1'b1; mode = ~m; addr_field = ~a; reg_idx = ~r; pc = ~p;
            end
            @(posedge clk);
            edges++;
            @(negedge clk);
            start = 1'b0;
        end
        check(done === 1'b1, "R3", "done seen", int'(done), 1);
        check(operand === e_op, t, "operand", int'(operand), int'(e_op));
        check(eff_addr === e_ea, t, "eff_addr", int'(eff_addr), int'(e_ea));
        check(nrd - n0 == n, poke ? "R2" : t, "read count", nrd - n0, n);
        check(edges == 1 + 2 * n, "R11", "latency edges", edges, 1 + 2 * n);
        if (n >= 1 && nrd - n0 >= 1)
            check(rd_log[n0 % 1024] === a1, t, "first read addr",
                  int'(rd_log[n0 % 1024]), int'(a1));
        if (n == 2 && nrd - n0 >= 2)
            check(rd_log[(n0 + 1) % 1024] === a2, t, "second read addr",
                  int'(rd_log[(n0 + 1) % 1024]), int'(a2));
        held_op = operand; held_ea = eff_addr;
        @(posedge clk);
        @(negedge clk);
        check(done === 1'b0, "R3", "done one cycle", int'(done), 0);
        check(operand === held_op && eff_addr === held_ea, "R3", "result held",
              int'(operand), int'(held_op));
    endtask

    initial begin
        #(200000 * 5);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 73 + 29) ^ (i >> 3));
        for (int i = 0; i < 16; i++) rf[i] = 8'(i * 17 + 3);
        rf[5] = 8'hF8;
        rf[9] = 8'h20;

        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R1",
              "ctrl outputs in reset", int'({busy, done, mem_req}), 0);
        check(operand === 8'd0 && eff_addr === 8'd0, "R1", "results in reset",
              int'(operand), 0);
        rst_n = 1'b1;

        // directed corners
        run_op(4'd0, 8'h5A, 4'd1, 8'h10, 1'b0);   // R4 immediate
        run_op(4'd12, 8'hC3, 4'd2, 8'h10, 1'b0);  // R4 undefined code
        run_op(4'd3, 8'h00, 4'd5, 8'h00, 1'b0);   // R5 register
        run_op(4'd1, 8'h44, 4'd0, 8'h00, 1'b0);   // R6 direct
        run_op(4'd4, 8'h00, 4'd7, 8'h00, 1'b0);   // R6 register-indirect
        run_op(4'd5, 8'hF0, 4'd9, 8'h00, 1'b0);   // R6 R10 displacement wrap
        run_op(4'd6, 8'hC0, 4'd0, 8'h50, 1'b0);   // R6 R10 relative wrap
        run_op(4'd2, 8'h12, 4'd0, 8'h00, 1'b0);   // R7 indirect
        run_op(4'd7, 8'h10, 4'd5, 8'h00, 1'b0);   // R8 R10 pre-indexed wrap
        run_op(4'd8, 8'h33, 4'd5, 8'h00, 1'b0);   // R9 R10 post-indexed wrap
        run_op(4'd8, 8'h02, 4'd9, 8'h00, 1'b1);   // R2 start while busy
        run_op(4'd0, 8'h77, 4'd3, 8'h00, 1'b1);   // R2 during short op

        // constrained random
        for (int k = 0; k < 300; k++) begin
            logic [3:0] m;
            logic [3:0] r;
            m = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'($urandom % 9);
            r = 4'($urandom % 16);
            rf[r] = ($urandom % 4 == 0) ? 8'hF0 + 8'($urandom % 16) : 8'($urandom);
            run_op(m, 8'($urandom), r, 8'($urandom), ($urandom % 5) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule